// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Decoder

This block turns the 255-wide comparator word of an 8-bit parallel converter into a binary sample. On every rising clock edge the comparator word is captured in a latch stage; the captured word is then cleaned, reduced to the position of its single one-to-zero edge, and encoded into a registered 8-bit code that counts how many reference steps the input sits above the bottom of the ladder.

Real comparators are not perfect. One of them may disagree with its neighbours, and the comparator nearest the input level may not have settled when it is latched. The decoder runs a three-wide majority window over the captured word and then encodes the edge position through a Gray-coded stage. An isolated wrong bit far from the edge is removed completely. A wrong bit close to the edge moves the result by at most one code, so one misbehaving comparator can never push the output to full scale or to zero scale.

There is no flow control. A comparator bank produces one word per clock and cannot be stalled, so the block takes a word every cycle and gives a code every cycle.

Top module: `flash_code_decoder`

## Requirements
- R1: The word on `cmp_i` at a rising edge is captured at that edge. The code for that word appears on `code_o` after the next rising edge. Until then `code_o` keeps its previous value.
- R2: For a clean thermometer word with bits 0 to k-1 set and all other bits clear (k from 0 to 255), `code_o` equals k.
- R3: With all 255 comparator bits set (input above full scale), `code_o` is 255 (all ones).
- R4: With all comparator bits clear (input below zero scale), `code_o` is 0.
- R5: With exactly the low 128 bits set (zero differential input), `code_o` is 128 (0x80), the mid-scale code.
- R6: Take a clean word with k bits set and flip one bit at index q, where q lies from k-2 to k+1 (the region of unsettled comparators). `code_o` is then within plus or minus 1 of k.
- R7: Take a clean word with k bits set and flip one bit at index q, where q is at most k-3 or at least k+2. `code_o` is then exactly k. This includes a lone set top bit (index 254) on an all-zero word, which gives 0, not full scale.
- R8: While `rst` is high at a rising edge, both the latch stage and `code_o` are cleared to 0. On the first edge after `rst` is released, `code_o` shows the code for a cleared latch, which is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; comparators are captured on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 255 | Comparator word; bit i is set when the input lies above threshold i+1 |
| code_o | output | 8 | Registered binary sample code |

## Verification
The hardest situation to reach is a wrong bit sitting one or two places from the true edge. That is where the majority window and the edge detector interact, and where the result may legitimately be off by one. It happens only when the flipped index lands in a four-position window around a particular fill level. The stimulus therefore builds every word from a chosen fill level k and a chosen flip index q. The table places q on each position of that window for the same k, and also just outside it on both sides. A long random run then draws k and q independently and classifies each case by its distance from the edge, so it checks for an exact result or a plus-or-minus-one result as the requirements say.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

  localparam int DEF_RES = 8;

  function automatic int gray_of(input int v);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/cmp_latch.sv
module cmp_latch #(
  parameter int W = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/bubble_vote.sv
module bubble_vote #(
  parameter int W = 255
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);

  // bit below index 0 is the ladder bottom (always 1), bit above the top is 0
  logic [W+1:0] ext;
  assign ext = {1'b0, raw, 1'b1};

  for (genvar i = 0; i < W; i++) begin : g_vote
    logic lo, mid, hi;
    assign lo  = ext[i];
    assign mid = ext[i+1];
    assign hi  = ext[i+2];
    assign clean[i] = (lo & mid) | (mid & hi) | (lo & hi);
  end

endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int W = 255
) (
  input  logic [W-1:0] th,
  output logic [W:0]   hit
);

  logic [W+1:0] ext;
  assign ext = {1'b0, th, 1'b1};

  // hit[j]: position j holds the last one before the first zero
  for (genvar j = 0; j <= W; j++) begin : g_edge
    assign hit[j] = ext[j] & ~ext[j+1];
  end

endmodule

// File: rtl/gray_encoder.sv
module gray_encoder #(
  parameter int RES = 8
) (
  input  logic [2**RES-1:0] hit,
  output logic [RES-1:0]    bin
);

  localparam int NPOS = 2**RES;

  logic [RES-1:0][NPOS-1:0] sel;
  logic [RES-1:0]           gray;

  for (genvar j = 0; j < NPOS; j++) begin : g_row
    localparam logic [RES-1:0] GJ = RES'(flash_dec_pkg::gray_of(j));
    for (genvar b = 0; b < RES; b++) begin : g_col
      assign sel[b][j] = hit[j] & GJ[b];
    end
  end

  for (genvar b = 0; b < RES; b++) begin : g_or
    assign gray[b] = |sel[b];
  end

  for (genvar i = 0; i < RES; i++) begin : g_bin
    assign bin[i] = ^gray[RES-1:i];
  end

endmodule

// File: rtl/flash_code_decoder.sv
module flash_code_decoder #(
  parameter int RES = flash_dec_pkg::DEF_RES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2**RES-2:0] cmp_i,
  output logic [RES-1:0]    code_o
);

  localparam int NCMP = 2**RES - 1;
  localparam int NPOS = 2**RES;

  logic [NCMP-1:0] lat;
  logic [NCMP-1:0] voted;
  logic [NPOS-1:0] hit;
  logic [RES-1:0]  dec_code;

  cmp_latch #(.W(NCMP)) u_latch (
    .clk (clk),
    .rst (rst),
    .d   (cmp_i),
    .q   (lat)
  );

  bubble_vote #(.W(NCMP)) u_vote (
    .raw   (lat),
    .clean (voted)
  );

  edge_detect #(.W(NCMP)) u_edge (
    .th  (voted),
    .hit (hit)
  );

  gray_encoder #(.RES(RES)) u_enc (
    .hit (hit),
    .bin (dec_code)
  );

  always_ff @(posedge clk) begin
    if (rst) code_o <= '0;
    else     code_o <= dec_code;
  end

  // ---- checks on the latched word against the registered code ----
  logic [NCMP-1:0] lat_inc;
  logic [NCMP+1:0] lat_ext;
  logic            lat_clean;
  int              ones_n;
  int              trans_n;
  int              iso_n;
  int              code_n;

  assign lat_inc   = lat + 1'b1;
  assign lat_clean = ((lat & lat_inc) == '0);
  assign lat_ext   = {1'b0, lat, 1'b1};
  assign ones_n    = $countones(lat);
  assign trans_n   = $countones(lat_ext[NCMP:0] ^ lat_ext[NCMP+1:1]);
  assign iso_n     = $countones((lat_ext[NCMP:1] ^ lat_ext[NCMP-1:0]) &
                                (lat_ext[NCMP:1] ^ lat_ext[NCMP+1:2]));
  assign code_n    = int'(code_o);

  p_clean_exact_r2: assert property (@(posedge clk) disable iff (rst)
    lat_clean |=> (code_n == $past(ones_n)));

  p_full_scale_r3: assert property (@(posedge clk) disable iff (rst)
    (&lat) |=> (&code_o));

  p_zero_scale_r4: assert property (@(posedge clk) disable iff (rst)
    (lat == '0) |=> (code_o == '0));

  p_one_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    ((trans_n == 1) || ((trans_n == 3) && (iso_n != 0))) |=>
    ((code_n >= $past(ones_n) - 1) && (code_n <= $past(ones_n) + 1)));

endmodule

// File: tb/flash_code_decoder_test.sv
`timescale 1ns/1ps
module flash_code_decoder_test;

  localparam int RES  = 8;
  localparam int NCMP = 2**RES - 1;
  localparam int NTBL = 16;

  // entry: {k[7:0], flip_en, q[7:0], exact}
  localparam logic [17:0] TBL [NTBL] = '{
    {8'd0,   1'b0, 8'd0,   1'b1},  // R4 zero scale
    {8'd255, 1'b0, 8'd0,   1'b1},  // R3 full scale
    {8'd128, 1'b0, 8'd0,   1'b1},  // R5 mid scale
    {8'd1,   1'b0, 8'd0,   1'b1},  // R2
    {8'd254, 1'b0, 8'd0,   1'b1},  // R2
    {8'd77,  1'b0, 8'd0,   1'b1},  // R2
    {8'd0,   1'b1, 8'd254, 1'b1},  // R7 lone top bit
    {8'd255, 1'b1, 8'd0,   1'b1},  // R7 lone low hole
    {8'd100, 1'b1, 8'd40,  1'b1},  // R7
    {8'd100, 1'b1, 8'd101, 1'b0},  // R6 q=k+1
    {8'd100, 1'b1, 8'd99,  1'b0},  // R6 q=k-1
    {8'd100, 1'b1, 8'd98,  1'b0},  // R6 q=k-2
    {8'd100, 1'b1, 8'd100, 1'b0},  // R6 q=k
    {8'd100, 1'b1, 8'd102, 1'b1},  // R7 q=k+2
    {8'd100, 1'b1, 8'd97,  1'b1},  // R7 q=k-3
    {8'd0,   1'b1, 8'd0,   1'b0}   // R6 near bottom
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCMP-1:0] cmp = '0;
  logic [RES-1:0]  code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_code_decoder #(.RES(RES)) uut (
    .clk    (clk),
    .rst    (rst),
    .cmp_i  (cmp),
    .code_o (code)
  );

  function automatic logic [NCMP-1:0] make_vec(input int k, input bit en, input int q);
    logic [NCMP-1:0] v;
    v = '0;
    for (int i = 0; i < NCMP; i++) if (i < k) v[i] = 1'b1;
    if (en) v[q] = ~v[q];
    return v;
  endfunction

  task automatic check_code(input string req, input int exp, input bit exact);
    int act;
    bit ok;
    act = int'(code);
    ok  = exact ? (act == exp) : ((act >= exp - 1) && (act <= exp + 1));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d%s", req, act, exp, exact ? "" : " +/-1");
    end
  endtask

  // drive at a falling edge, two rising edges to the output, sample at a falling edge
  task automatic run_vec(input string req, input int k, input bit en, input int q, input bit exact);
    cmp = make_vec(k, en, q);
    @(negedge clk);
    @(negedge clk);
    check_code(req, k, exact);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state: all ones presented while in reset
    cmp = make_vec(255, 1'b0, 0);
    repeat (3) @(negedge clk);
    check_code("R8", 0, 1'b1);
    rst = 1'b0;
    cmp = '0;
    @(negedge clk);

    // table walk
    for (int t = 0; t < NTBL; t++) begin
      string req;
      if (!TBL[t][9])      req = (TBL[t][17:10] == 8'd0)   ? "R4" :
                                 (TBL[t][17:10] == 8'd255) ? "R3" :
                                 (TBL[t][17:10] == 8'd128) ? "R5" : "R2";
      else if (TBL[t][0])  req = "R7";
      else                 req = "R6";
      run_vec(req, int'(TBL[t][17:10]), TBL[t][9], int'(TBL[t][8:1]), TBL[t][0]);
    end

    // R1 latency: one capture edge, then one output edge
    cmp = '0;
    @(negedge clk); @(negedge clk);
    cmp = make_vec(50, 1'b0, 0);
    @(negedge clk);
    check_code("R1", 0, 1'b1);
    cmp = make_vec(60, 1'b0, 0);
    @(negedge clk);
    check_code("R1", 50, 1'b1);
    @(negedge clk);
    check_code("R1", 60, 1'b1);

    // R8 mid-run reset clears the latch as well as the output
    cmp = make_vec(255, 1'b0, 0);
    @(negedge clk); @(negedge clk);
    check_code("R3", 255, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_code("R8", 0, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check_code("R8", 0, 1'b1);
    @(negedge clk);
    check_code("R8", 255, 1'b1);

    // random clean and single-bubble words: R2, R6, R7
    for (int n = 0; n < 400; n++) begin
      int  k, q;
      bit  en, ex;
      k  = $urandom_range(0, 255);
      q  = $urandom_range(0, NCMP - 1);
      en = ($urandom_range(0, 3) != 0);
      ex = !en || (q <= k - 3) || (q >= k + 2);
      run_vec(!en ? "R2" : (ex ? "R7" : "R6"), k, en, q, ex);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule